// File: doc/BRIEF.md
# Processor Trace Status Encoder

This block sits beside a processor core and turns its execution events into two 4-bit streams for an external trace probe. The status stream reports what the core is doing. The data stream carries the target address of each taken branch whose destination cannot be known from the program image alone. Both streams are registered and change on every trace clock edge.

Five kinds of event drive the status stream: a taken branch, exception processing, debug-mode processing, the stopped state and the halted state. The last four are level inputs, and a fixed priority decides which code wins. A taken branch is reported as 0x5. If the branch uses variant addressing, its 32-bit target is also captured. A byte-count marker follows on the status stream, and after it the target bytes appear on the data stream, least significant byte first. A one-entry buffer holds one further variant branch while a transfer is running.

Top module: `trc_status_enc`

## Requirements
- R1: A taken branch sampled at a clock edge shows status 0x5 during the following cycle, unless a higher-priority code is active.
- R2: For a variant branch, the status code in the cycle after the 0x5 is a marker of value 0x8 plus (byte count - 1). The count comes from the configuration value captured with the branch: 2'b01 selects 2 bytes (0x9), 2'b10 selects 3 bytes (0xA), and 2'b11 or 2'b00 selects 4 bytes (0xB).
- R3: The data port starts in the cycle after the marker and carries 2*N nibbles, one per cycle. Nibble k is target bits [4k+3:4k], so bytes go out low byte first and each byte low nibble first.
- R4: A taken branch that is not a variant branch produces only 0x5. No marker follows and the data port stays 0x0.
- R5: The data port shows 0x0 in every cycle that carries no address nibble.
- R6: While a level input is held, the status code one cycle later and in each following cycle is 0xC for exception, 0xD for debug mode, 0xE for stopped and 0xF for halted.
- R7: When several sources coincide, the status code is chosen in this order: halted (0xF), debug mode (0xD), exception (0xC), stopped (0xE), new branch (0x5), marker, then normal execution (0x0).
- R8: A marker that is blocked by a higher-priority code or by a new branch is deferred, not lost. Its data nibbles begin only in the cycle after the marker is actually shown.
- R9: A variant branch that arrives while a transfer is pending is buffered. Its marker appears in the cycle after the current transfer's last nibble, and its nibbles follow.
- R10: A variant branch that arrives while the buffer is already full is reported as 0x5 only. Its address never appears.
- R11: Synchronous reset drives both ports to 0x0 and discards the active transfer and the buffered transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst | input | 1 | Synchronous active-high reset |
| br_taken_i | input | 1 | A branch was taken in this cycle |
| br_variant_i | input | 1 | The taken branch uses variant addressing (return, indirect or indexed jump or call, exception vector) |
| br_target_i | input | 32 | Target address of the taken branch |
| cfg_nbytes_i | input | 2 | Target byte count: 01=2, 10=3, 11 or 00=4 |
| exc_active_i | input | 1 | Exception processing in progress |
| dbg_active_i | input | 1 | Debug-mode processing in progress |
| stop_active_i | input | 1 | Core is stopped and waiting for an interrupt |
| halt_active_i | input | 1 | Core is halted until restart or reset |
| pst_o | output | 4 | Registered status code |
| ddata_o | output | 4 | Registered data nibble |

## Verification
Two functions can fall in the same cycle, and the bench provokes both cases. In the first, a deferred marker meets a new branch: a plain branch is issued in the cycle right after a variant branch, so the second 0x5 and the first marker compete for the status port. The expected result is 0x5, then the marker one cycle late, then the data one cycle late. In the second, a marker meets exception processing: the exception level is held across the cycle in which the marker would appear. The bench expects 0xC for the whole hold, the marker in the first free cycle, and 0x0 on the data port until then.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int TRC_ADDR_W  = 32;
    localparam int TRC_NIB_W   = 4;
    localparam int TRC_NIBS    = TRC_ADDR_W / TRC_NIB_W;
    localparam int TRC_IDX_W   = $clog2(TRC_NIBS);
    localparam int TRC_NBM1_W  = TRC_IDX_W - 1;

    typedef enum logic [TRC_NIB_W-1:0] {
        PST_NORMAL = 4'h0,
        PST_BRANCH = 4'h5,
        PST_MARK1  = 4'h8,
        PST_MARK2  = 4'h9,
        PST_MARK3  = 4'hA,
        PST_MARK4  = 4'hB,
        PST_EXC    = 4'hC,
        PST_DBG    = 4'hD,
        PST_STOP   = 4'hE,
        PST_HALT   = 4'hF
    } pst_e;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_MARK = 2'd1,
        SER_DATA = 2'd2
    } ser_state_e;

    typedef struct packed {
        logic [TRC_ADDR_W-1:0] addr;
        logic [TRC_NBM1_W-1:0] nb_m1;
    } xfer_t;

    // Configuration field to (byte count - 1); reserved 00 means full width
    function automatic logic [TRC_NBM1_W-1:0] cfg_to_nbm1(input logic [1:0] cfg);
        logic [TRC_NBM1_W-1:0] r;
        case (cfg)
            2'b01:   r = TRC_NBM1_W'(1);
            2'b10:   r = TRC_NBM1_W'(2);
            default: r = TRC_NBM1_W'(3);
        endcase
        return r;
    endfunction

    function automatic pst_e marker_code(input logic [TRC_NBM1_W-1:0] nb_m1);
        return pst_e'(4'h8 | TRC_NIB_W'(nb_m1));
    endfunction

    function automatic logic [TRC_NIB_W-1:0] nibble_at(input logic [TRC_ADDR_W-1:0] a,
                                                       input logic [TRC_IDX_W-1:0] idx);
        logic [TRC_ADDR_W-1:0] s;
        s = a >> {idx, 2'b00};
        return s[TRC_NIB_W-1:0];
    endfunction

    function automatic logic [TRC_IDX_W-1:0] last_index(input logic [TRC_NBM1_W-1:0] nb_m1);
        return {nb_m1, 1'b1};
    endfunction

endpackage

// File: rtl/trc_addr_queue.sv
module trc_addr_queue
    import trc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push_i,
    input  xfer_t push_xfer_i,
    input  logic  pop_i,
    output logic  valid_o,
    output xfer_t head_o
);

    logic  valid_q;
    xfer_t head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            head_q  <= '0;
        end else if (push_i) begin
            valid_q <= 1'b1;
            head_q  <= push_xfer_i;
        end else if (pop_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign head_o  = head_q;

    // A full entry may only be replaced in the cycle it drains
    assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (rst)
        (valid_q && push_i) |-> pop_i);

    assert_pop_needs_entry_R9: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> valid_q);

endmodule

// File: rtl/trc_addr_ser.sv
module trc_addr_ser
    import trc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  xfer_t                load_xfer_i,
    input  logic                 mark_grant_i,
    output logic                 mark_req_o,
    output pst_e                 mark_code_o,
    output logic                 can_load_o,
    output logic                 busy_o,
    output logic [TRC_NIB_W-1:0] ddata_o
);

    ser_state_e           state_q;
    xfer_t                cur_q;
    logic [TRC_IDX_W-1:0] idx_q;
    logic [TRC_NIB_W-1:0] ddata_q;
    logic                 in_data;
    logic                 last_nib;

    assign in_data  = (state_q == SER_DATA);
    assign last_nib = in_data && (idx_q == last_index(cur_q.nb_m1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SER_IDLE;
            cur_q   <= '0;
            idx_q   <= '0;
            ddata_q <= '0;
        end else begin
            case (state_q)
                SER_IDLE: begin
                    ddata_q <= '0;
                    if (load_i) begin
                        cur_q   <= load_xfer_i;
                        state_q <= SER_MARK;
                    end
                end
                SER_MARK: begin
                    ddata_q <= '0;
                    if (mark_grant_i) begin
                        idx_q   <= '0;
                        state_q <= SER_DATA;
                    end
                end
                SER_DATA: begin
                    ddata_q <= nibble_at(cur_q.addr, idx_q);
                    if (last_nib) begin
                        if (load_i) begin
                            cur_q   <= load_xfer_i;
                            state_q <= SER_MARK;
                        end else begin
                            state_q <= SER_IDLE;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: begin
                    ddata_q <= '0;
                    state_q <= SER_IDLE;
                end
            endcase
        end
    end

    assign mark_req_o  = (state_q == SER_MARK);
    assign mark_code_o = marker_code(cur_q.nb_m1);
    assign can_load_o  = (state_q == SER_IDLE) || last_nib;
    assign busy_o      = (state_q != SER_IDLE);
    assign ddata_o     = ddata_q;

    // Data never starts without the marker having been granted
    assert_marker_before_data_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(in_data) |-> $past(mark_grant_i));

    assert_nibble_order_R3: assert property (@(posedge clk) disable iff (rst)
        (in_data && !last_nib) |=> (in_data && idx_q == $past(idx_q) + 1'b1));

    assert_grant_only_when_waiting_R8: assert property (@(posedge clk) disable iff (rst)
        mark_grant_i |-> mark_req_o);

endmodule

// File: rtl/trc_prio_sel.sv
module trc_prio_sel
    import trc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 halt_i,
    input  logic                 dbg_i,
    input  logic                 exc_i,
    input  logic                 stop_i,
    input  logic                 br_i,
    input  logic                 mark_req_i,
    input  pst_e                 mark_code_i,
    output logic                 mark_grant_o,
    output logic [TRC_NIB_W-1:0] pst_o
);

    pst_e pst_d;
    pst_e pst_q;
    logic level_busy;

    assign level_busy = halt_i || dbg_i || exc_i || stop_i;

    always_comb begin
        if (halt_i)          pst_d = PST_HALT;
        else if (dbg_i)      pst_d = PST_DBG;
        else if (exc_i)      pst_d = PST_EXC;
        else if (stop_i)     pst_d = PST_STOP;
        else if (br_i)       pst_d = PST_BRANCH;
        else if (mark_req_i) pst_d = mark_code_i;
        else                 pst_d = PST_NORMAL;
    end

    assign mark_grant_o = mark_req_i && !level_busy && !br_i;

    always_ff @(posedge clk) begin
        if (rst) pst_q <= PST_NORMAL;
        else     pst_q <= pst_d;
    end

    assign pst_o = pst_q;

    assert_halt_wins_R7: assert property (@(posedge clk) disable iff (rst)
        halt_i |=> (pst_o == 4'hF));

    assert_branch_reported_R1: assert property (@(posedge clk) disable iff (rst)
        (br_i && !level_busy) |=> (pst_o == 4'h5));

endmodule

// File: rtl/trc_status_enc.sv
module trc_status_enc
    import trc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        br_taken_i,
    input  logic        br_variant_i,
    input  logic [31:0] br_target_i,
    input  logic [1:0]  cfg_nbytes_i,
    input  logic        exc_active_i,
    input  logic        dbg_active_i,
    input  logic        stop_active_i,
    input  logic        halt_active_i,
    output logic [3:0]  pst_o,
    output logic [3:0]  ddata_o
);

    xfer_t new_xfer;
    xfer_t q_head;
    xfer_t ser_load_xfer;
    logic  var_br;
    logic  q_valid;
    logic  q_push;
    logic  q_pop;
    logic  direct_load;
    logic  ser_load;
    logic  ser_can_load;
    logic  ser_busy;
    logic  mark_req;
    logic  mark_grant;
    pst_e  mark_code;

    assign var_br        = br_taken_i && br_variant_i;
    assign new_xfer.addr  = br_target_i;
    assign new_xfer.nb_m1 = cfg_to_nbm1(cfg_nbytes_i);

    // The buffered branch is older, so it always goes to the serializer first
    assign q_pop         = q_valid && ser_can_load;
    assign direct_load   = !q_valid && var_br && ser_can_load;
    assign q_push        = var_br && !direct_load && (!q_valid || q_pop);
    assign ser_load      = q_valid || var_br;
    assign ser_load_xfer = q_valid ? q_head : new_xfer;

    trc_addr_queue u_queue (
        .clk         (clk),
        .rst         (rst),
        .push_i      (q_push),
        .push_xfer_i (new_xfer),
        .pop_i       (q_pop),
        .valid_o     (q_valid),
        .head_o      (q_head)
    );

    trc_addr_ser u_ser (
        .clk          (clk),
        .rst          (rst),
        .load_i       (ser_load),
        .load_xfer_i  (ser_load_xfer),
        .mark_grant_i (mark_grant),
        .mark_req_o   (mark_req),
        .mark_code_o  (mark_code),
        .can_load_o   (ser_can_load),
        .busy_o       (ser_busy),
        .ddata_o      (ddata_o)
    );

    trc_prio_sel u_prio (
        .clk          (clk),
        .rst          (rst),
        .halt_i       (halt_active_i),
        .dbg_i        (dbg_active_i),
        .exc_i        (exc_active_i),
        .stop_i       (stop_active_i),
        .br_i         (br_taken_i),
        .mark_req_i   (mark_req),
        .mark_code_i  (mark_code),
        .mark_grant_o (mark_grant),
        .pst_o        (pst_o)
    );

    assert_queue_behind_busy_R9: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> ser_busy);

    assert_idle_data_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (!ser_busy && !$past(ser_busy)) |-> (ddata_o == 4'h0));

endmodule

// File: tb/trc_status_enc_tb.sv
module trc_status_enc_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        br_taken_i;
    logic        br_variant_i;
    logic [31:0] br_target_i;
    logic [1:0]  cfg_nbytes_i;
    logic        exc_active_i;
    logic        dbg_active_i;
    logic        stop_active_i;
    logic        halt_active_i;
    logic [3:0]  pst_o;
    logic [3:0]  ddata_o;

    int n_vec = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trc_status_enc dut_i (
        .clk           (clk),
        .rst           (rst),
        .br_taken_i    (br_taken_i),
        .br_variant_i  (br_variant_i),
        .br_target_i   (br_target_i),
        .cfg_nbytes_i  (cfg_nbytes_i),
        .exc_active_i  (exc_active_i),
        .dbg_active_i  (dbg_active_i),
        .stop_active_i (stop_active_i),
        .halt_active_i (halt_active_i),
        .pst_o         (pst_o),
        .ddata_o       (ddata_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [3:0] got, input logic [3:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic quiet();
        br_taken_i = 0; br_variant_i = 0;
        exc_active_i = 0; dbg_active_i = 0; stop_active_i = 0; halt_active_i = 0;
    endtask

    task automatic settle();
        quiet();
        for (int i = 0; i < 12; i++) step();
    endtask

    function automatic int nbytes(input logic [1:0] cfg);
        return (cfg == 2'b00) ? 4 : int'(cfg) + 1;
    endfunction

    function automatic logic [3:0] nib(input logic [31:0] a, input int k);
        return 4'((a >> (4 * k)) & 32'hF);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_vec++; n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [3:0]  e;
        quiet();
        br_target_i = '0; cfg_nbytes_i = 2'b11;
        rst = 1;
        step(); step();
        chk("R11", "reset status", pst_o, 4'h0);
        chk("R11", "reset data", ddata_o, 4'h0);
        rst = 0;
        step();

        // R2 R3 R5: variant branch sweep over all configurations and patterns
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int p = 0; p < 8; p++) begin
                a = 32'h1234_5678 ^ (32'(p) * 32'h9E37_79B9);
                br_taken_i = 1; br_variant_i = 1; br_target_i = a; cfg_nbytes_i = 2'(cfg);
                step();
                quiet(); br_target_i = '0; cfg_nbytes_i = 2'b01;
                chk("R1", "branch code", pst_o, 4'h5);
                step();
                chk("R2", "marker", pst_o, 4'(8 + nbytes(2'(cfg)) - 1));
                chk("R5", "data before start", ddata_o, 4'h0);
                for (int k = 0; k < 2 * nbytes(2'(cfg)); k++) begin
                    step();
                    chk("R3", "address nibble", ddata_o, nib(a, k));
                    chk("R3", "status during data", pst_o, 4'h0);
                end
                step();
                chk("R5", "data after end", ddata_o, 4'h0);
                settle();
            end
        end

        // R4: plain branches carry no address
        for (int p = 0; p < 8; p++) begin
            br_taken_i = 1; br_variant_i = 0; br_target_i = 32'hFFFF_FFFF - 32'(p); cfg_nbytes_i = 2'b11;
            step();
            quiet();
            chk("R4", "plain branch code", pst_o, 4'h5);
            for (int k = 0; k < 10; k++) begin
                step();
                chk("R4", "plain branch status", pst_o, 4'h0);
                chk("R4", "plain branch data", ddata_o, 4'h0);
            end
        end

        // R6 R7: sweep all level and branch combinations
        for (int m = 0; m < 32; m++) begin
            halt_active_i = m[0]; dbg_active_i = m[1]; exc_active_i = m[2];
            stop_active_i = m[3]; br_taken_i = m[4]; br_variant_i = 0;
            step();
            e = m[0] ? 4'hF : m[1] ? 4'hD : m[2] ? 4'hC : m[3] ? 4'hE : m[4] ? 4'h5 : 4'h0;
            chk("R7", "priority", pst_o, e);
            quiet();
            step();
        end

        // R6: codes held for as long as the level stays
        for (int w = 0; w < 4; w++) begin
            halt_active_i = (w == 0); dbg_active_i = (w == 1);
            exc_active_i = (w == 2); stop_active_i = (w == 3);
            e = (w == 0) ? 4'hF : (w == 1) ? 4'hD : (w == 2) ? 4'hC : 4'hE;
            for (int k = 0; k < 4; k++) begin
                step();
                chk("R6", "held level code", pst_o, e);
            end
            quiet();
            step(); step();
            chk("R6", "level released", pst_o, 4'h0);
        end

        // R8: a new branch collides with a due marker
        a = 32'hA5C3_1E7F;
        br_taken_i = 1; br_variant_i = 1; br_target_i = a; cfg_nbytes_i = 2'b01;
        step();
        br_variant_i = 0; br_target_i = '0;
        chk("R1", "first branch", pst_o, 4'h5);
        step();
        quiet();
        chk("R8", "branch beats marker", pst_o, 4'h5);
        chk("R8", "no data yet", ddata_o, 4'h0);
        step();
        chk("R8", "deferred marker", pst_o, 4'h9);
        chk("R8", "no data with marker", ddata_o, 4'h0);
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R8", "deferred data", ddata_o, nib(a, k));
        end
        settle();

        // R8: exception processing holds off the marker
        a = 32'h0F1E_2D3C;
        br_taken_i = 1; br_variant_i = 1; br_target_i = a; cfg_nbytes_i = 2'b10;
        step();
        quiet();
        chk("R1", "branch before exception", pst_o, 4'h5);
        exc_active_i = 1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R8", "exception masks marker", pst_o, 4'hC);
            chk("R8", "data held during exception", ddata_o, 4'h0);
        end
        exc_active_i = 0;
        step();
        chk("R8", "marker after exception", pst_o, 4'hA);
        chk("R8", "data still idle", ddata_o, 4'h0);
        for (int k = 0; k < 6; k++) begin
            step();
            chk("R8", "data after exception", ddata_o, nib(a, k));
        end
        settle();

        // R9 R10: buffered branch and dropped third branch
        a = 32'h1357_9BDF; b = 32'h2468_ACE0; c = 32'hDEAD_BEEF;
        br_taken_i = 1; br_variant_i = 1; br_target_i = a; cfg_nbytes_i = 2'b01;
        step();
        br_target_i = b;
        chk("R1", "branch A", pst_o, 4'h5);
        step();
        quiet();
        chk("R9", "branch B code", pst_o, 4'h5);
        step();
        chk("R9", "marker A", pst_o, 4'h9);
        br_taken_i = 1; br_variant_i = 1; br_target_i = c; cfg_nbytes_i = 2'b11;
        step();
        quiet();
        chk("R10", "branch C code", pst_o, 4'h5);
        chk("R9", "A nibble 0", ddata_o, nib(a, 0));
        for (int k = 1; k < 4; k++) begin
            step();
            chk("R9", "A nibble", ddata_o, nib(a, k));
        end
        step();
        chk("R9", "marker B", pst_o, 4'h9);
        chk("R9", "gap between transfers", ddata_o, 4'h0);
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R9", "B nibble", ddata_o, nib(b, k));
        end
        for (int k = 0; k < 8; k++) begin
            step();
            chk("R10", "no marker for C", pst_o, 4'h0);
            chk("R10", "no data for C", ddata_o, 4'h0);
        end
        settle();

        // R11: reset in the middle of a transfer with one buffered
        br_taken_i = 1; br_variant_i = 1; br_target_i = 32'h7777_7777; cfg_nbytes_i = 2'b11;
        step();
        br_target_i = 32'h9999_9999;
        step();
        quiet();
        step(); step(); step();
        rst = 1;
        step();
        chk("R11", "reset mid transfer status", pst_o, 4'h0);
        chk("R11", "reset mid transfer data", ddata_o, 4'h0);
        rst = 0;
        for (int k = 0; k < 12; k++) begin
            step();
            chk("R11", "pending cleared status", pst_o, 4'h0);
            chk("R11", "pending cleared data", ddata_o, 4'h0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule